// File: doc/BRIEF.md
# Phase Comparator and Charge-Pump Controller

This block compares a divided reference pulse train with a divided feedback pulse train. Both come from the frequency dividers of a fractional-N loop and are sampled on the system clock. It produces the pump-up and pump-down commands that steer an external charge pump. Alongside these it gives a 3-bit magnitude code, which selects the pump current from two select bits and a doubling bit, and a single status pin. That pin normally shows whether the loop has locked.

A 6-bit test code can take over the outputs. It can hold the pump in continuous source or continuous sink. It can also put the sampled reference or feedback divider signal onto the status pin, so the dividers can be probed. Test codes that are not defined fall back to normal pumping with the status pin held low.

The comparator is a state machine with four states: `PF_IDLE`, `PF_UP`, `PF_DN` and `PF_BOTH`.
- From `PF_IDLE`, a reference edge alone goes to `PF_UP`, a feedback edge alone goes to `PF_DN`, and both edges together go to `PF_BOTH`.
- From `PF_UP`, a feedback edge goes to `PF_BOTH`.
- From `PF_DN`, a reference edge goes to `PF_BOTH`.
- `PF_BOTH` returns to `PF_IDLE` once the reset delay has run out.

The lock monitor has two states, `LK_HUNT` and `LK_HELD`.
- It moves from `LK_HUNT` to `LK_HELD` after enough short comparisons in a row.
- It moves from `LK_HELD` back to `LK_HUNT` as soon as a one-sided pulse becomes too wide.

Top module: `pd_cp_ctrl`

## Requirements
- R1: A rising edge on `ref_div` starts a comparison. The input is seen high at a clock edge after being low at the edge before. While the comparator is idle and no feedback edge arrives with it, `pump_up` is high and `pump_dn` is low from the second clock edge after the sample.
- R2: A rising edge on `fb_div` works the same way while the comparator is idle and no reference edge arrives with it. `pump_dn` is high and `pump_up` is low from the second clock edge after the sample.
- R3: Once the edge of the other input has also arrived, `pump_up` and `pump_dn` are both high for exactly `RST_DLY` clocks (default 2), and then both fall in the same cycle.
- R4: Divider edges that arrive while both pump outputs are high are ignored. After the reset window both outputs are low.
- R5: `cp_code` equals `{cp_double, cp_sel}`, registered once. Codes 0 to 7 map to the nominal currents 170, 350, 520, 690, 340, 670, 1000 and 1310 µA, so bit 2 roughly doubles the current.
- R6: Test code 6'b000001 forces `pump_up`=1 and `pump_dn`=0. Test code 6'b000010 forces `pump_up`=0 and `pump_dn`=1.
- R7: Test code 6'b010000 puts `ref_div`, delayed by one clock, on `lock_out`. Test code 6'b011000 puts `fb_div`, delayed by one clock, on `lock_out`.
- R8: Any test code other than the five defined ones gives normal pump behaviour with `lock_out` low. With codes 000000, 000001 and 000010, `lock_out` shows the lock state.
- R9: Lock is declared after `LOCK_N` (64) comparisons in a row, each with a one-sided pulse width below `LOCK_W` (4) clocks.
- R10: A comparison whose one-sided width is between `LOCK_W` and `UNLOCK_W` (8) clocks, inclusive, clears the count of good comparisons but does not clear a held lock.
- R11: Lock is cleared in the cycle where a one-sided pulse reaches `UNLOCK_W`+1 clocks. A width of exactly `UNLOCK_W` keeps the lock.
- R12: During reset, `pump_up`, `pump_dn`, `cp_code` and `lock_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_div | input | 1 | Divided reference pulse |
| fb_div | input | 1 | Divided feedback pulse |
| cp_sel | input | 2 | Pump current select |
| cp_double | input | 1 | Pump current doubling |
| test_code | input | 6 | Test-mode select |
| pump_up | output | 1 | Charge-pump source command |
| pump_dn | output | 1 | Charge-pump sink command |
| cp_code | output | 3 | Pump current magnitude code |
| lock_out | output | 1 | Lock status or routed divider signal |

## Verification
The hardest condition to reach from the ports is the hysteresis of the lock monitor. The internal count of good comparisons must be cleared by a single medium-width comparison without any visible change on `lock_out`. To expose this, the stimulus sends long trains of phase-offset pulse pairs with exact gap lengths. A medium gap is placed partway through a run, and the bench then shows that the full count of good comparisons is needed again before lock appears. Feedback-leading pairs and ignored edges that arrive during the reset window are reached by placing pulses on exact clock cycles.

// File: rtl/pd_pkg.sv
package pd_pkg;

    typedef enum logic [1:0] {
        PF_IDLE,
        PF_UP,
        PF_DN,
        PF_BOTH
    } pfd_state_t;

    typedef enum logic {
        LK_HUNT,
        LK_HELD
    } lk_state_t;

    localparam int TC_W = 6;
    localparam logic [TC_W-1:0] TC_NORMAL = 6'b000000;
    localparam logic [TC_W-1:0] TC_SRC    = 6'b000001;
    localparam logic [TC_W-1:0] TC_SNK    = 6'b000010;
    localparam logic [TC_W-1:0] TC_REF    = 6'b010000;
    localparam logic [TC_W-1:0] TC_FB     = 6'b011000;

endpackage

// File: rtl/pd_edge.sv
module pd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise
);
    logic d1_q, d2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d1_q <= 1'b0;
            d2_q <= 1'b0;
        end else begin
            d1_q <= din;
            d2_q <= d1_q;
        end
    end

    assign lvl  = d1_q;
    assign rise = d1_q & ~d2_q;
endmodule

// File: rtl/pd_pfd_fsm.sv
module pd_pfd_fsm
    import pd_pkg::*;
#(
    parameter int RST_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic up,
    output logic dn
);
    localparam int DW = $clog2(RST_DLY + 2);
    localparam logic [DW-1:0] LAST = DW'(RST_DLY - 1);
    localparam logic [DW-1:0] FULL = DW'(RST_DLY);

    pfd_state_t state_q, state_d;
    logic [DW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PF_IDLE: begin
                if (ref_rise && fb_rise) state_d = PF_BOTH;
                else if (ref_rise)       state_d = PF_UP;
                else if (fb_rise)        state_d = PF_DN;
            end
            PF_UP:   if (fb_rise)  state_d = PF_BOTH;
            PF_DN:   if (ref_rise) state_d = PF_BOTH;
            PF_BOTH: if (cnt_q == LAST) state_d = PF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PF_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == PF_BOTH && state_d == PF_BOTH) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        up = 1'b0;
        dn = 1'b0;
        unique case (state_q)
            PF_IDLE: ;
            PF_UP:   up = 1'b1;
            PF_DN:   dn = 1'b1;
            PF_BOTH: begin
                up = 1'b1;
                dn = 1'b1;
            end
        endcase
    end

    // independent run-length of the overlap window
    logic [DW-1:0] both_run;
    always_ff @(posedge clk) begin
        if (!rst_n)           both_run <= '0;
        else if (up && dn)    both_run <= (both_run == FULL) ? both_run : both_run + 1'b1;
        else                  both_run <= '0;
    end

    assert_up_from_ref_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PF_IDLE && ref_rise && !fb_rise) |=> (up && !dn));

    assert_dn_from_fb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PF_IDLE && fb_rise && !ref_rise) |=> (dn && !up));

    assert_overlap_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(up && dn) && $past(up && dn)) |-> (both_run == FULL));
endmodule

// File: rtl/pd_lock_mon.sv
module pd_lock_mon
    import pd_pkg::*;
#(
    parameter int LOCK_N   = 64,
    parameter int LOCK_W   = 4,
    parameter int UNLOCK_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up,
    input  logic dn,
    output logic locked
);
    localparam int RW = $clog2(UNLOCK_W + 2);
    localparam int GW = $clog2(LOCK_N + 1);
    localparam logic [RW-1:0] SHORT_LIM = RW'(LOCK_W);
    localparam logic [RW-1:0] WIDE_LIM  = RW'(UNLOCK_W);
    localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_N - 1);

    lk_state_t state_q, state_d;
    logic [RW-1:0] run_w;
    logic [GW-1:0] good_q;
    logic both_q;
    logic end_evt, one_side, too_wide, short_run;

    assign end_evt   = up && dn && !both_q;
    assign one_side  = up ^ dn;
    assign too_wide  = one_side && (run_w >= WIDE_LIM);
    assign short_run = run_w < SHORT_LIM;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_HUNT: if (end_evt && short_run && good_q == GOOD_LAST) state_d = LK_HELD;
            LK_HELD: if (too_wide) state_d = LK_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_HUNT;
            run_w   <= '0;
            good_q  <= '0;
            both_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            both_q  <= up && dn;
            if (end_evt) begin
                run_w  <= '0;
                good_q <= short_run ? ((good_q == GOOD_LAST) ? good_q : good_q + 1'b1) : '0;
            end else if (one_side) begin
                if (run_w <= WIDE_LIM) run_w <= run_w + 1'b1;
                if (too_wide) good_q <= '0;
            end else begin
                run_w <= '0;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            LK_HUNT: locked = 1'b0;
            LK_HELD: locked = 1'b1;
        endcase
    end

    assert_wide_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && one_side) |-> (run_w <= WIDE_LIM));

    assert_lock_from_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(end_evt && short_run));
endmodule

// File: rtl/pd_cp_ctrl.sv
module pd_cp_ctrl
    import pd_pkg::*;
#(
    parameter int RST_DLY  = 2,
    parameter int LOCK_N   = 64,
    parameter int LOCK_W   = 4,
    parameter int UNLOCK_W = 8,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_div,
    input  logic             fb_div,
    input  logic [SEL_W-1:0] cp_sel,
    input  logic             cp_double,
    input  logic [TC_W-1:0]  test_code,
    output logic             pump_up,
    output logic             pump_dn,
    output logic [SEL_W:0]   cp_code,
    output logic             lock_out
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw, lvl, rise;
    logic pfd_up, pfd_dn, locked;

    assign raw = {fb_div, ref_div};

    for (genvar gi = 0; gi < NCH; gi++) begin : g_edge
        pd_edge u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[gi]),
            .lvl  (lvl[gi]),
            .rise (rise[gi])
        );
    end

    pd_pfd_fsm #(.RST_DLY(RST_DLY)) u_pfd (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_rise(rise[0]),
        .fb_rise (rise[1]),
        .up      (pfd_up),
        .dn      (pfd_dn)
    );

    pd_lock_mon #(.LOCK_N(LOCK_N), .LOCK_W(LOCK_W), .UNLOCK_W(UNLOCK_W)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .up    (pfd_up),
        .dn    (pfd_dn),
        .locked(locked)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) cp_code <= '0;
        else        cp_code <= {cp_double, cp_sel};
    end

    always_comb begin
        pump_up  = pfd_up;
        pump_dn  = pfd_dn;
        lock_out = 1'b0;
        unique case (test_code)
            TC_NORMAL: lock_out = locked;
            TC_SRC: begin
                pump_up  = 1'b1;
                pump_dn  = 1'b0;
                lock_out = locked;
            end
            TC_SNK: begin
                pump_up  = 1'b0;
                pump_dn  = 1'b1;
                lock_out = locked;
            end
            TC_REF:  lock_out = lvl[0];
            TC_FB:   lock_out = lvl[1];
            default: lock_out = 1'b0;
        endcase
    end

    assert_cp_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cp_code == $past({cp_double, cp_sel})));

    assert_force_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (test_code == TC_SRC) |-> (pump_up && !pump_dn));

    assert_undef_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (test_code != TC_NORMAL && test_code != TC_SRC && test_code != TC_SNK &&
         test_code != TC_REF && test_code != TC_FB) |-> !lock_out);
endmodule

// File: tb/pd_cp_ctrl_bench.sv
`timescale 1ns/1ps
module pd_cp_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_div = 1'b0, fb_div = 1'b0, cp_double = 1'b0;
    logic [1:0] cp_sel = 2'b00;
    logic [5:0] test_code = 6'b0;
    logic pump_up, pump_dn, lock_out;
    logic [2:0] cp_code;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    pd_cp_ctrl u_pd_cp_ctrl (
        .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .fb_div(fb_div),
        .cp_sel(cp_sel), .cp_double(cp_double), .test_code(test_code),
        .pump_up(pump_up), .pump_dn(pump_dn), .cp_code(cp_code), .lock_out(lock_out)
    );

    // {code[14:9], ref, fb, dbl, sel[1:0], exp_up, exp_dn, chk_pump, exp_lock}
    localparam logic [14:0] VEC [10] = '{
        {6'b000001, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0},
        {6'b000010, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0},
        {6'b010000, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1},
        {6'b010000, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0},
        {6'b011000, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1},
        {6'b011000, 1'b1, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0},
        {6'b000011, 1'b1, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0},
        {6'b100000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0},
        {6'b010001, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0},
        {6'b000001, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_div = 1'b0; fb_div = 1'b0; test_code = 6'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // one comparison: leader high at step 0, follower at step gap
    task automatic compare(input bit ref_leads, input int gap, input bit chk, input string tag);
        @(negedge clk);
        if (ref_leads || gap == 0) ref_div = 1'b1;
        if (!ref_leads || gap == 0) fb_div = 1'b1;
        for (int k = 1; k <= gap + 7; k++) begin
            @(negedge clk);
            if (k == gap && gap > 0) begin
                ref_div = 1'b1;
                fb_div = 1'b1;
            end
            if (chk && k == 2 && gap >= 1) begin
                check(ref_leads ? {"R1 up ", tag} : {"R2 dn ", tag}, {30'd0, pump_up, pump_dn},
                      ref_leads ? 32'h2 : 32'h1);
            end
            if (chk && (k == gap + 2 || k == gap + 3))
                check({"R3 overlap ", tag}, {30'd0, pump_up, pump_dn}, 32'h3);
            if (chk && k == gap + 4)
                check({"R3 release ", tag}, {30'd0, pump_up, pump_dn}, 32'h0);
            if (k == gap + 5) begin
                ref_div = 1'b0;
                fb_div = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cp_sel = 2'b11; cp_double = 1'b1;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 pumps", {30'd0, pump_up, pump_dn}, 32'h0);
        check("R12 cp_code", {29'd0, cp_code}, 32'h0);
        check("R12 lock_out", {31'd0, lock_out}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table of test-code and current-code vectors (R5 R6 R7 R8)
        foreach (VEC[i]) begin
            test_code = VEC[i][14:9];
            ref_div = VEC[i][8];
            fb_div = VEC[i][7];
            cp_double = VEC[i][6];
            cp_sel = VEC[i][5:4];
            repeat (3) @(negedge clk);
            check("R5 cp_code", {29'd0, cp_code}, {29'd0, VEC[i][6:4]});
            if (VEC[i][1])
                check("R6 forced pump", {30'd0, pump_up, pump_dn}, {30'd0, VEC[i][3:2]});
            check("R7/R8 lock_out routing", {31'd0, lock_out}, {31'd0, VEC[i][0]});
        end

        // R1/R2/R3: polarity and overlap window
        do_reset();
        compare(1'b1, 3, 1'b1, "ref lead 3");
        compare(1'b0, 3, 1'b1, "fb lead 3");
        compare(1'b1, 1, 1'b1, "ref lead 1");
        compare(1'b0, 0, 1'b1, "simultaneous");

        // R4: edge inside the overlap window is ignored
        @(negedge clk); ref_div = 1'b1; fb_div = 1'b1;
        @(negedge clk); ref_div = 1'b0;
        @(negedge clk); ref_div = 1'b1;
        check("R4 overlap", {30'd0, pump_up, pump_dn}, 32'h3);
        @(negedge clk);
        @(negedge clk);
        check("R4 ignored edge", {30'd0, pump_up, pump_dn}, 32'h0);
        @(negedge clk);
        check("R4 still idle", {30'd0, pump_up, pump_dn}, 32'h0);
        ref_div = 1'b0; fb_div = 1'b0;
        repeat (3) @(negedge clk);

        // R9: lock after 64 short comparisons
        do_reset();
        for (int n = 0; n < 63; n++) compare(n % 2 == 0, 2, 1'b0, "");
        check("R9 not yet locked at 63", {31'd0, lock_out}, 32'h0);
        compare(1'b1, 2, 1'b0, "");
        check("R9 locked at 64", {31'd0, lock_out}, 32'h1);

        // R10: medium width keeps lock
        compare(1'b0, 6, 1'b0, "");
        check("R10 medium keeps lock", {31'd0, lock_out}, 32'h1);
        // R11: width 8 keeps, width 9 drops
        compare(1'b1, 8, 1'b0, "");
        check("R11 width 8 keeps lock", {31'd0, lock_out}, 32'h1);
        compare(1'b0, 9, 1'b0, "");
        check("R11 width 9 drops lock", {31'd0, lock_out}, 32'h0);

        // R10: medium width clears the good count while hunting
        do_reset();
        for (int n = 0; n < 40; n++) compare(1'b1, 1, 1'b0, "");
        compare(1'b1, 5, 1'b0, "");
        for (int n = 0; n < 40; n++) compare(1'b0, 3, 1'b0, "");
        check("R10 count cleared", {31'd0, lock_out}, 32'h0);
        for (int n = 0; n < 24; n++) compare(1'b1, 0, 1'b0, "");
        check("R10 locked after fresh run", {31'd0, lock_out}, 32'h1);

        // R8: undefined code hides lock but pumps stay normal
        test_code = 6'b000100;
        compare(1'b1, 3, 1'b1, "undefined code");
        check("R8 undefined lock low", {31'd0, lock_out}, 32'h0);
        test_code = 6'b000000;
        @(negedge clk);
        check("R8 normal shows lock", {31'd0, lock_out}, 32'h1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule